// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit

This unit multiplies two source operands and then combines the 32-bit product with a third 32-bit operand. The multiply has three forms. The narrow form uses the low 16 bits of each source. The wide form uses the low 24 bits of each source. The wide-high form also uses 24-bit sources but returns the upper 32 bits of the 48-bit product. Each form comes in signed and unsigned flavours. A 4-bit mode code picks one of nine variants, and three of those variants also clamp a signed overflow to the nearest representable value.

The accumulate step can add the third source to the product, subtract it from the product, subtract the product from it, or add it with an incoming carry. The unit reports carry, overflow, negative and zero flags. When multiply-only is asserted, the accumulate step is skipped and the product is returned directly. In that case the two narrow sources can each be treated as signed or unsigned on their own.

The datapath is a two-register pipeline. The first register holds the product and the decoded controls. The second register holds the result and the flags. There are no control states: every stage accepts a new operation on every cycle, and a valid bit travels with the data.

Top module: `imac_unit`

## Requirements
- R1: Mode codes 0 and 1 select the narrow multiply. The low 16 bits of each source are zero-extended (code 0) or sign-extended (code 1), and the product is kept modulo 2^32.
- R2: Mode codes 3 and 4 select the wide multiply. The low 24 bits of each source are zero-extended (code 3) or sign-extended (code 4) to 48 bits, and product bits 31:0 are used.
- R3: Mode codes 6 (unsigned) and 7 (signed) select the wide-high multiply, which uses product bits 47:16.
- R4: Codes 2, 5 and 8 behave like 1, 4 and 7 respectively, but with saturation enabled. Codes 9 to 15 behave like code 0, with no saturation.
- R5: acc_op selects how the product P and the third source Q are combined:
  - 00 gives P+Q.
  - 01 gives P+~Q+1.
  - 10 gives ~P+Q+1.
  - 11 gives P+Q+carry_in.
- R6: flag_c is bit 32 of the full-precision accumulate sum. flag_v is set when the two addends have equal bit 31 and the wrapped sum has a different bit 31.
- R7: In a saturating mode with flag_v set, the result is clamped. It becomes 0x7FFFFFFF when the wrapped sum has bit 31 set, and 0x80000000 otherwise. In non-saturating modes the wrapped sum is returned.
- R8: flag_n equals result bit 31, and flag_z is set exactly when result is zero.
- R9: When mul_only is 1, the result is the product and flag_c and flag_v are 0. In this case src_c, acc_op, carry_in and saturation have no effect.
- R10: When mul_only is 1 and the mode is narrow (codes 0-2 or 9-15), mo_sign_a and mo_sign_b choose the extension of each source (1 = signed). These inputs are ignored in wide modes and whenever mul_only is 0.
- R11: A result and out_valid appear exactly two cycles after an accepted in_valid. A new operation can be accepted every cycle, and out_valid is 0 two cycles after a cycle with in_valid low.
- R12: While rst_n is low, out_valid, result and all flags are 0. An operation in flight when reset is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs |
| src_a | input | 32 | First multiply source |
| src_b | input | 32 | Second multiply source |
| src_c | input | 32 | Accumulate operand |
| mul_code | input | 4 | Multiply mode code |
| acc_op | input | 2 | Accumulate operation |
| carry_in | input | 1 | Carry used by acc_op 11 |
| mul_only | input | 1 | Skip the accumulate step |
| mo_sign_a | input | 1 | Narrow multiply-only: src_a is signed |
| mo_sign_b | input | 1 | Narrow multiply-only: src_b is signed |
| out_valid | output | 1 | result and flags are valid |
| result | output | 32 | Final value |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |

## Verification
Each result is due two clock edges after the edge that samples in_valid. The first edge loads the product register and the second loads the result register.

The bench drives inputs just after a falling edge and streams the vector table with one operation per cycle. It compares the output for vector i at the falling edge where vector i+2 is being driven. Directed tests send a single isolated operation and confirm out_valid is still low after one edge and high after the second. They also reset the unit while an operation is in flight and confirm the outputs clear.

// File: rtl/imac_pkg.sv
package imac_pkg;

    typedef enum logic [1:0] {
        ACC_ADD  = 2'b00,
        ACC_SUB  = 2'b01,
        ACC_RSUB = 2'b10,
        ACC_ADDC = 2'b11
    } acc_op_e;

    // Decoded multiply variant
    typedef struct packed {
        logic wide;   // 24-bit lanes instead of 16-bit
        logic high;   // return upper product word
        logic sgn;    // sign-extend both sources
        logic sat;    // clamp signed accumulate overflow
    } mul_cfg_t;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

endpackage

// File: rtl/imac_decode.sv
module imac_decode
    import imac_pkg::*;
(
    input  logic [3:0] code,
    output mul_cfg_t   cfg
);

    always_comb begin
        cfg = '0;
        unique case (code)
            4'd0: ;
            4'd1: cfg.sgn = 1'b1;
            4'd2: begin cfg.sgn = 1'b1; cfg.sat = 1'b1; end
            4'd3: cfg.wide = 1'b1;
            4'd4: begin cfg.wide = 1'b1; cfg.sgn = 1'b1; end
            4'd5: begin cfg.wide = 1'b1; cfg.sgn = 1'b1; cfg.sat = 1'b1; end
            4'd6: begin cfg.wide = 1'b1; cfg.high = 1'b1; end
            4'd7: begin cfg.wide = 1'b1; cfg.high = 1'b1; cfg.sgn = 1'b1; end
            4'd8: begin
                cfg.wide = 1'b1; cfg.high = 1'b1; cfg.sgn = 1'b1; cfg.sat = 1'b1;
            end
            default: ;  // unassigned codes fall back to unsigned narrow
        endcase
    end

endmodule

// File: rtl/imac_mul_stage.sv
module imac_mul_stage
    import imac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  mul_cfg_t          cfg,
    input  acc_op_e           acc_op,
    input  logic              carry_in,
    input  logic              mul_only,
    input  logic              mo_sign_a,
    input  logic              mo_sign_b,
    output logic              s1_valid,
    output logic [DATA_W-1:0] s1_prod,
    output logic [DATA_W-1:0] s1_addend,
    output acc_op_e           s1_op,
    output logic              s1_cin,
    output logic              s1_sat,
    output logic              s1_mul_only
);

    localparam int NARROW_W = DATA_W / 2;
    localparam int WIDE_W   = (DATA_W * 3) / 4;
    localparam int PROD_W   = (DATA_W * 3) / 2;

    function automatic logic [PROD_W-1:0] widen(input logic [DATA_W-1:0] x,
                                                input logic wide, input logic sgn);
        logic [PROD_W-1:0] r;
        if (wide)
            r = {{(PROD_W-WIDE_W){sgn & x[WIDE_W-1]}}, x[WIDE_W-1:0]};
        else
            r = {{(PROD_W-NARROW_W){sgn & x[NARROW_W-1]}}, x[NARROW_W-1:0]};
        return r;
    endfunction

    logic [DATA_W-1:0] raw     [2];
    logic [1:0]        mo_sign;
    logic [1:0]        lane_sgn;
    logic [PROD_W-1:0] ext     [2];
    logic [PROD_W-1:0] full;
    logic [DATA_W-1:0] prod;
    logic              unused_hi;

    assign raw[0]  = src_a;
    assign raw[1]  = src_b;
    assign mo_sign = {mo_sign_b, mo_sign_a};

    // Per-source extension
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_sgn[g] = (mul_only && !cfg.wide) ? mo_sign[g] : cfg.sgn;
        assign ext[g]      = widen(raw[g], cfg.wide, lane_sgn[g]);
    end

    assign full = ext[0] * ext[1];
    assign prod = cfg.high ? full[PROD_W-1 -: DATA_W] : full[DATA_W-1:0];

    assign unused_hi = ^{src_a[DATA_W-1:WIDE_W], src_b[DATA_W-1:WIDE_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_prod     <= '0;
            s1_addend   <= '0;
            s1_op       <= ACC_ADD;
            s1_cin      <= 1'b0;
            s1_sat      <= 1'b0;
            s1_mul_only <= 1'b0;
        end else begin
            s1_valid    <= in_valid;
            s1_prod     <= prod;
            s1_addend   <= src_c;
            s1_op       <= acc_op;
            s1_cin      <= carry_in;
            s1_sat      <= cfg.sat & ~mul_only;
            s1_mul_only <= mul_only;
        end
    end

    AST_STAGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);  // R11

    AST_NARROW_UNSIGNED_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cfg.wide && !lane_sgn[0] && !lane_sgn[1])
            |=> (s1_prod <= {NARROW_W'(0) - NARROW_W'(1), NARROW_W'(1)}));  // R1

endmodule

// File: rtl/imac_acc_stage.sv
module imac_acc_stage
    import imac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_valid,
    input  logic [DATA_W-1:0] s1_prod,
    input  logic [DATA_W-1:0] s1_addend,
    input  acc_op_e           s1_op,
    input  logic              s1_cin,
    input  logic              s1_sat,
    input  logic              s1_mul_only,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);

    localparam int                MSB     = DATA_W - 1;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] opa, opb, wrapped, acc_res, nxt_res;
    logic              cin, ovf;
    logic [DATA_W:0]   sum;
    flags_t            nxt_flags;

    always_comb begin
        opa = s1_prod;
        opb = s1_addend;
        cin = 1'b0;
        unique case (s1_op)
            ACC_ADD:  ;
            ACC_SUB:  begin opb = ~s1_addend; cin = 1'b1; end
            ACC_RSUB: begin opa = ~s1_prod;   cin = 1'b1; end
            ACC_ADDC: cin = s1_cin;
        endcase
    end

    assign sum     = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin};
    assign wrapped = sum[DATA_W-1:0];
    assign ovf     = (opa[MSB] == opb[MSB]) && (opa[MSB] != wrapped[MSB]);
    assign acc_res = (s1_sat && ovf) ? (wrapped[MSB] ? MAX_POS : MIN_NEG) : wrapped;

    always_comb begin
        if (s1_mul_only) begin
            nxt_res     = s1_prod;
            nxt_flags.c = 1'b0;
            nxt_flags.v = 1'b0;
        end else begin
            nxt_res     = acc_res;
            nxt_flags.c = sum[DATA_W];
            nxt_flags.v = ovf;
        end
        nxt_flags.n = nxt_res[MSB];
        nxt_flags.z = (nxt_res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= s1_valid;
            result    <= nxt_res;
            flags     <= nxt_flags;
        end
    end

    AST_MULONLY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mul_only) |=> (!flags.c && !flags.v));  // R9

    AST_MULONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mul_only) |=> (result == $past(s1_prod)));  // R9

    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_sat && !s1_mul_only)
            |=> (!flags.v || result == MAX_POS || result == MIN_NEG));  // R7

    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((flags.n == result[MSB]) && (flags.z == (result == '0))));  // R8

endmodule

// File: rtl/imac_unit.sv
module imac_unit
    import imac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic [3:0]        mul_code,
    input  logic [1:0]        acc_op,
    input  logic              carry_in,
    input  logic              mul_only,
    input  logic              mo_sign_a,
    input  logic              mo_sign_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_c,
    output logic              flag_v,
    output logic              flag_n,
    output logic              flag_z
);

    mul_cfg_t          cfg;
    logic              s1_valid, s1_cin, s1_sat, s1_mul_only;
    logic [DATA_W-1:0] s1_prod, s1_addend;
    acc_op_e           s1_op;
    flags_t            flags;

    imac_decode i_decode (
        .code (mul_code),
        .cfg  (cfg)
    );

    imac_mul_stage #(.DATA_W(DATA_W)) i_mul (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .src_a       (src_a),
        .src_b       (src_b),
        .src_c       (src_c),
        .cfg         (cfg),
        .acc_op      (acc_op_e'(acc_op)),
        .carry_in    (carry_in),
        .mul_only    (mul_only),
        .mo_sign_a   (mo_sign_a),
        .mo_sign_b   (mo_sign_b),
        .s1_valid    (s1_valid),
        .s1_prod     (s1_prod),
        .s1_addend   (s1_addend),
        .s1_op       (s1_op),
        .s1_cin      (s1_cin),
        .s1_sat      (s1_sat),
        .s1_mul_only (s1_mul_only)
    );

    imac_acc_stage #(.DATA_W(DATA_W)) i_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_valid    (s1_valid),
        .s1_prod     (s1_prod),
        .s1_addend   (s1_addend),
        .s1_op       (s1_op),
        .s1_cin      (s1_cin),
        .s1_sat      (s1_sat),
        .s1_mul_only (s1_mul_only),
        .out_valid   (out_valid),
        .result      (result),
        .flags       (flags)
    );

    assign flag_c = flags.c;
    assign flag_v = flags.v;
    assign flag_n = flags.n;
    assign flag_z = flags.z;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);  // R11

    AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);  // R11

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && result == '0 && !flag_c && !flag_v && !flag_n && !flag_z));  // R12

endmodule

// File: tb/test_imac_unit.sv
module test_imac_unit;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [3:0]  mode;
        logic [1:0]  op;
        logic        cin;
        logic        mo;
        logic        sa;
        logic        sb;
        logic [31:0] res;
        logic [3:0]  flg;   // {C, V, N, Z}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{32'h00010003, 32'hFFFF0005, 32'd10, 4'd0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000019, 4'b0000, 4'd1},  // R1 u16 add
        '{32'h0000FFFE, 32'h00000003, 32'd4, 4'd1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFF6, 4'b1010, 4'd5},   // R5 s16 sub
        '{32'h00000002, 32'h00000003, 32'd10, 4'd0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00000004, 4'b1000, 4'd5},  // R5 reverse sub
        '{32'h0000FFFF, 32'h00000001, 32'hFFFF0000, 4'd0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 4'b1001, 4'd6},  // R6 addc carry out
        '{32'h12FFFFFF, 32'h00000002, 32'd0, 4'd3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h01FFFFFE, 4'b0000, 4'd2},   // R2 u24
        '{32'h00FFFFFF, 32'h00800000, 32'd1, 4'd4, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00800001, 4'b0000, 4'd2},   // R2 s24
        '{32'h00FFFFFF, 32'h00FFFFFF, 32'd0, 4'd6, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFFFE00, 4'b0010, 4'd3},   // R3 high u24
        '{32'h00FFFFFF, 32'h00000100, 32'd1, 4'd7, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'b1001, 4'd3},          // R3 high s24
        '{32'h00007FFF, 32'h00007FFF, 32'h7FFFFFFF, 4'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 4'b0100, 4'd7},  // R7 clamp up
        '{32'h00800000, 32'h00000100, 32'h80000000, 4'd5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h80000000, 4'b1110, 4'd7},  // R7 clamp down
        '{32'h00400000, 32'h00400000, 32'h70000000, 4'd8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 4'b0100, 4'd4},  // R4 code 8
        '{32'h0000FFFF, 32'h0000FFFF, 32'h80000000, 4'd9, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7FFE0001, 4'b1100, 4'd4},  // R4 code 9
        '{32'h00007FFF, 32'h00007FFF, 32'h7FFFFFFF, 4'd1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'hBFFF0000, 4'b0110, 4'd6},  // R6 overflow, no clamp
        '{32'h00FFFFFF, 32'h00FFFFFE, 32'hFFFFFFFF, 4'd4, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000002, 4'b0000, 4'd9},  // R9 mul-only
        '{32'h00FFFFFF, 32'h00000005, 32'd0, 4'd5, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFB, 4'b0010, 4'd9},   // R9 no sat
        '{32'h0000FFFF, 32'h0000FFFF, 32'd0, 4'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF0001, 4'b0010, 4'd10},  // R10 a signed
        '{32'h00000002, 32'h0000FFFF, 32'd0, 4'd1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 32'hFFFFFFFE, 4'b0010, 4'd10},  // R10 b signed
        '{32'h0000FFFF, 32'h0000FFFF, 32'd0, 4'd2, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 32'hFFFE0001, 4'b0010, 4'd10},  // R10 both unsigned
        '{32'h0000FFFF, 32'h0000FFFF, 32'd0, 4'd0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFE0001, 4'b0010, 4'd10},  // R10 ignored w/ accumulate
        '{32'h01000000, 32'h00000005, 32'd0, 4'd3, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 4'b0001, 4'd8},          // R8 zero product
        '{32'h00FFFFFF, 32'h00000002, 32'd0, 4'd3, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 32'h01FFFFFE, 4'b0000, 4'd10},  // R10 ignored wide
        '{32'h00008000, 32'h00000002, 32'd0, 4'd15, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00010000, 4'b0000, 4'd4}   // R4 code 15
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] src_a, src_b, src_c;
    logic [3:0]  mul_code;
    logic [1:0]  acc_op;
    logic        carry_in, mul_only, mo_sign_a, mo_sign_b;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_c, flag_v, flag_n, flag_z;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    imac_unit i_imac_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .src_c     (src_c),
        .mul_code  (mul_code),
        .acc_op    (acc_op),
        .carry_in  (carry_in),
        .mul_only  (mul_only),
        .mo_sign_a (mo_sign_a),
        .mo_sign_b (mo_sign_b),
        .out_valid (out_valid),
        .result    (result),
        .flag_c    (flag_c),
        .flag_v    (flag_v),
        .flag_n    (flag_n),
        .flag_z    (flag_z)
    );

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid  = vld;
        src_a     = v.a;
        src_b     = v.b;
        src_c     = v.c;
        mul_code  = v.mode;
        acc_op    = v.op;
        carry_in  = v.cin;
        mul_only  = v.mo;
        mo_sign_a = v.sa;
        mo_sign_b = v.sb;
    endtask

    task automatic check_vec(input int idx);
        vec_t v;
        v = VECS[idx];
        chk(11, $sformatf("vec %0d out_valid", idx), {31'd0, out_valid}, 32'd1);
        chk(int'(v.req), $sformatf("vec %0d result", idx), result, v.res);
        chk(int'(v.req), $sformatf("vec %0d flags CVNZ", idx),
            {28'd0, flag_c, flag_v, flag_n, flag_z}, {28'd0, v.flg});
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[0], 1'b0);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(12, "reset out_valid", {31'd0, out_valid}, 32'd0);
        chk(12, "reset result", result, 32'd0);
        chk(12, "reset flags", {28'd0, flag_c, flag_v, flag_n, flag_z}, 32'd0);
        rst_n = 1'b1;

        // R11 single operation latency
        @(negedge clk);
        drive(VECS[0], 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(11, "one edge: not yet valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk(11, "two edges: valid", {31'd0, out_valid}, 32'd1);
        chk(1, "isolated result", result, 32'h00000019);
        @(negedge clk);
        chk(11, "bubble follows", {31'd0, out_valid}, 32'd0);

        // Table streamed back to back
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_vec(i - 2);
            if (i < NV) drive(VECS[i], 1'b1);
            else        in_valid = 1'b0;
        end
        @(negedge clk);
        chk(11, "idle after stream", {31'd0, out_valid}, 32'd0);

        // R12 reset discards an operation in flight
        drive(VECS[3], 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        #1;
        chk(12, "mid-flight reset out_valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(12, "discarded op stays invalid", {31'd0, out_valid}, 32'd0);
        chk(12, "discarded op result", result, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule